// File: doc/BRIEF.md
# Dual-Compare Event Timer

This block is an 8-bit up counter that moves forward by one on every tick from an external clock-select stage. The tick is a one-clock strobe in the system clock domain. On each tick, two compare channels check the counter against their own compare values. A match on a channel sets that channel's sticky interrupt flag. If the channel's toggle enable is set, the match also inverts the channel's waveform pin. When the counter rolls over from its top value to zero, it sets an overflow flag.

Software uses a small register port to read and write the counter, both compare values, the flag register and the toggle enables. Any write to the counter arms a one-shot block, and the next tick then raises no compare match. Loading a value equal to a compare register therefore does not fire that channel. A write that jumps the counter past a compare value skips that match, and this is intended.

Top module: `dual_cmp_timer`

## Requirements
- R1: After the asynchronous reset, the counter, both compare values, all flags, the toggle enables and both waveform pins are zero.
- R2: The register map has these addresses: 0 is the counter, 1 is compare A, 2 is compare B, 3 is the flag register and 4 is the toggle enable register. A write takes effect at the next clock. A read returns data on rdata_o in the same cycle. Addresses 0 to 2 read back the value last written.
- R3: Each tick with no counter write in the same cycle adds one to the counter. From 255 the counter goes to 0.
- R4: A tick that rolls the counter over sets the overflow flag (flag register bit 2, pin irq_ovf_o). A pending write block does not stop the overflow flag.
- R5: A channel matches on an unblocked tick when the counter value before the increment equals the channel's compare value. A match sets the channel's flag: bit 0 and irq_o[0] for A, bit 1 and irq_o[1] for B.
- R6: Matches are checked only on ticks. Holding the counter equal to a compare value over many clocks without a tick sets nothing, and one match event sets the flag once.
- R7: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it as it is. If a set and a clear happen in the same clock, the set wins.
- R8: A match inverts a channel's waveform pin (wave_o[0] for A, wave_o[1] for B) only while that channel's enable bit is 1 (bit 0 for A, bit 1 for B at address 4). Otherwise the pin holds its value.
- R9: A counter write blocks all compare matches on the first tick after it. The tick after that one matches normally.
- R10: If a counter write and a tick arrive in the same clock, the written value is loaded and the increment from that tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count strobe from the clock-select stage, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 2 | Compare match flags, bit 0 for A and bit 1 for B |
| irq_ovf_o | output | 1 | Overflow flag |
| wave_o | output | 2 | Toggling waveform pins, bit 0 for A and bit 1 for B |

## Verification
The assertions check on every cycle that the counter steps by one on a plain tick and loads the written value when a write and a tick collide. They also check that a waveform pin holds while its enable is clear or while a tick is blocked, and that a flag rises only after a match evaluation. Some behaviour can only be shown by the bench's scenarios. These include: the match happening against the counter value before the increment, a single set for a held equality, write-one-to-clear with a write of 0 having no effect, and the overflow flag on rollover. The bench scenarios also show that the block lasts exactly one tick, by checking that the following tick matches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_N_CH = 2;
  localparam int unsigned TMR_AW   = 3;
  localparam logic [TMR_AW-1:0] A_CNT  = TMR_AW'(0);
  localparam logic [TMR_AW-1:0] A_CMP0 = TMR_AW'(1);
  localparam logic [TMR_AW-1:0] A_FLAG = TMR_AW'(TMR_N_CH + 1);
  localparam logic [TMR_AW-1:0] A_TGL  = TMR_AW'(TMR_N_CH + 2);
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         blocked_o,
  output logic         eval_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         block_q;
  logic         step;

  assign step = tick_i & ~wr_i;  // write wins over a tick

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      block_q <= 1'b0;
    end else begin
      if (wr_i)      cnt_q <= wdata_i;
      else if (step) cnt_q <= cnt_q + 1'b1;
      if (wr_i)      block_q <= 1'b1;
      else if (step) block_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign blocked_o = block_q;
  assign eval_o    = step & ~block_q;
  assign wrap_o    = step & (cnt_q == {W{1'b1}});

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
  // R10
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_cmp_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         eval_i,
  input  logic         tgl_en_i,
  input  logic         clr_i,
  output logic [W-1:0] cmp_o,
  output logic         flag_o,
  output logic         wave_o
);
  logic [W-1:0] cmp_q;
  logic         flag_q, wave_q, hit;

  assign hit = eval_i & (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (wr_cmp_i) cmp_q <= wdata_i;
      if (hit)        flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
      if (hit && tgl_en_i) wave_q <= ~wave_q;
    end
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
  assign wave_o = wave_q;

  // R8
  wave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgl_en_i |=> $stable(wave_q));
  // R6
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(eval_i));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [TMR_AW-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  output logic [TMR_N_CH-1:0] irq_o,
  output logic                irq_ovf_o,
  output logic [TMR_N_CH-1:0] wave_o
);
  localparam int unsigned OVF_BIT = TMR_N_CH;

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cmp [TMR_N_CH];
  logic                blocked, eval, wrap, wr_cnt, wr_flag, wr_tgl;
  logic [TMR_N_CH-1:0] tgl_en_q;
  logic                ovf_q;

  assign wr_cnt  = wr_en_i && (addr_i == A_CNT);
  assign wr_flag = wr_en_i && (addr_i == A_FLAG);
  assign wr_tgl  = wr_en_i && (addr_i == A_TGL);

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .wr_i(wr_cnt), .wdata_i,
    .cnt_o(cnt), .blocked_o(blocked), .eval_o(eval), .wrap_o(wrap)
  );

  for (genvar g = 0; g < TMR_N_CH; g++) begin : g_ch
    tmr_cmp_chan #(.W(CNT_W)) u_ch (
      .clk_i, .rst_ni,
      .wr_cmp_i(wr_en_i && (addr_i == TMR_AW'(A_CMP0 + g))),
      .wdata_i,
      .cnt_i(cnt),
      .eval_i(eval),
      .tgl_en_i(tgl_en_q[g]),
      .clr_i(wr_flag && wdata_i[g]),
      .cmp_o(cmp[g]),
      .flag_o(irq_o[g]),
      .wave_o(wave_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_en_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_tgl) tgl_en_q <= wdata_i[TMR_N_CH-1:0];
      if (wrap)                            ovf_q <= 1'b1;
      else if (wr_flag && wdata_i[OVF_BIT]) ovf_q <= 1'b0;
    end
  end

  assign irq_ovf_o = ovf_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CNT) rdata_o = cnt;
    for (int i = 0; i < TMR_N_CH; i++)
      if (addr_i == TMR_AW'(A_CMP0 + i)) rdata_o = cmp[i];
    if (addr_i == A_FLAG) rdata_o[OVF_BIT:0] = {ovf_q, irq_o};
    if (addr_i == A_TGL)  rdata_o[TMR_N_CH-1:0] = tgl_en_q;
  end

  // R9
  blk_wave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && blocked && !wr_cnt) |=> $stable(wave_o));
  // R4
  ovf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(tick_i && !wr_cnt));
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] irq_o, wave_o;
  logic       irq_ovf_o;

  int n_run = 0, n_fail = 0, cyc = 0;

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  bit    obs = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_cmp_timer u0 (.*);

  wire [7:0] pins = {3'b0, wave_o[1], wave_o[0], irq_ovf_o, irq_o[1], irq_o[0]};

  // monitor
  always @(negedge clk_i) begin
    if (obs && sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_pin ? pins : rdata_o;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit tk = 0);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; tick_i = tk;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(posedge clk_i); #1;
      tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    addr_i = a;
    sb_q.push_back('{1'b0, e, tag});
    obs = 1'b1;
    @(posedge clk_i); #1;
    obs = 1'b0;
  endtask

  task automatic pin(input logic [7:0] e, input string tag);
    sb_q.push_back('{1'b1, e, tag});
    obs = 1'b1;
    @(posedge clk_i); #1;
    obs = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1
    rd(0, 8'h00, "R1 cnt"); rd(1, 8'h00, "R1 cmpA"); rd(2, 8'h00, "R1 cmpB");
    rd(3, 8'h00, "R1 flags"); rd(4, 8'h00, "R1 tgl"); pin(8'h00, "R1 pins");
    // R2
    wr(1, 8'd2); wr(2, 8'd4); wr(4, 8'h03);
    rd(1, 8'd2, "R2 cmpA"); rd(2, 8'd4, "R2 cmpB"); rd(4, 8'h03, "R2 tgl");
    // R3 R5 R8
    tick(3);
    rd(0, 8'd3, "R3 cnt"); rd(3, 8'h01, "R5 flagA"); pin(8'h09, "R8 waveA");
    tick(2);
    rd(0, 8'd5, "R3 cnt"); rd(3, 8'h03, "R5 flagB"); pin(8'h1B, "R8 waveB");
    // R7
    wr(3, 8'h00); rd(3, 8'h03, "R7 w0 no effect");
    wr(3, 8'h01); rd(3, 8'h02, "R7 w1 clear");
    // R6: held equality without tick
    wr(1, 8'd5); idle(5); rd(3, 8'h02, "R6 no tick no match");
    tick(1);
    rd(3, 8'h03, "R6 match on tick"); rd(0, 8'd6, "R3 cnt"); pin(8'h13, "R8 waveA back");
    idle(4); wr(3, 8'h03); idle(4);
    rd(3, 8'h00, "R6 single set"); pin(8'h10, "R7 pins cleared");
    // R9
    wr(2, 8'd10); wr(0, 8'd10); tick(1);
    rd(0, 8'd11, "R9 cnt"); rd(3, 8'h00, "R9 blocked"); pin(8'h10, "R9 wave held");
    wr(0, 8'd9); tick(1); rd(3, 8'h00, "R9 blocked tick");
    tick(1); rd(3, 8'h02, "R9 next tick matches"); pin(8'h02, "R9 waveB");
    // R10
    wr(0, 8'h20, 1); rd(0, 8'h20, "R10 write wins");
    tick(1); rd(0, 8'h21, "R10 then counts"); rd(3, 8'h02, "R10 flags");
    // R4
    wr(3, 8'h03); wr(0, 8'hFE); tick(1);
    rd(0, 8'hFF, "R3 to max"); rd(3, 8'h00, "R4 no ovf yet");
    tick(1);
    rd(0, 8'h00, "R3 wrap"); rd(3, 8'h04, "R4 ovf flag"); pin(8'h04, "R4 ovf pin");
    wr(3, 8'h04); rd(3, 8'h00, "R7 ovf clear");
    // R8 disabled toggle
    wr(4, 8'h00); wr(1, 8'd2); tick(3);
    rd(3, 8'h01, "R8 flag still sets"); pin(8'h01, "R8 wave held");
    rd(4, 8'h00, "R2 tgl off");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule